// File: doc/BRIEF.md
# I2S Microphone Master Receiver

This block is the I2S bus master for one or two MEMS digital microphones that share a single serial data line. Everything runs on the system clock. A restart counter with a programmable limit toggles the bit clock each time it wraps. The block also drives the word-select line, which picks the talking microphone: low selects the left channel and high selects the right. The serial data line is sampled on falling bit-clock edges.

A channel slot is 32 bit-clock periods long. The first 18 bits, MSB first, form the sample and the remaining 14 bits are discarded. When a slot completes, the block shows the 18-bit sample, the channel it came from, and a one-cycle valid strobe. Setting the divider limit to N gives a bit clock of f_sys / (2·(N+1)). The integrator picks N so that the bit clock lands in the 2 to 4 MHz window the microphones accept. For example, a 20 MHz system clock with N = 4 gives 2 MHz.

Top module: `i2s_mic_rx`

## Requirements
- R1: While rst_ni is low, bclk_o, ws_o and sample_valid_o are all 0.
- R2: bclk_o toggles once every div_i+1 system clock cycles, where div_i is the counter limit.
- R3: sd_i is sampled in the system cycle in which bclk_o falls. Data changed by the microphone after a rising edge is therefore captured on the next falling edge.
- R4: ws_o changes only in the cycle in which bclk_o falls.
- R5: A slot spans 32 falling edges. ws_o toggles on the falling edge that latches the slot's 32nd bit, so after falling edge number f (counted from reset) ws_o equals (f/32) mod 2.
- R6: sample_o holds bits 1 to 18 of the slot, with bit 1 in sample_o[17]. Bits 19 to 32 have no effect on sample_o.
- R7: sample_valid_o is high for exactly one cycle, in the cycle after the system edge that latches bit 32. sample_o does not change while sample_valid_o is low.
- R8: While sample_valid_o is high, chan_o gives the ws_o level of the slot just captured: 0 for left and 1 for right.
- R9: After reset is released, the first slot is a left slot, and its MSB is latched on the first falling edge of bclk_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | Restart limit of the bit-clock counter |
| sd_i | input | 1 | Shared serial data from the microphones |
| bclk_o | output | 1 | Bit clock to the microphones |
| ws_o | output | 1 | Word select, 0 = left, 1 = right |
| sample_o | output | SAMPLE_W | Most recent captured sample |
| chan_o | output | 1 | Channel of sample_o |
| sample_valid_o | output | 1 | One-cycle strobe for a new sample |

## Verification
The microphone model changes data right after each rising edge. A receiver that sampled on the rising edge would therefore be one bit off in every sample. The discarded bits 19 to 32 are driven with non-zero patterns, so a shift register that kept running past bit 18 would corrupt the captured value. Word select is tracked against a falling-edge count kept by the bench. A toggle one bit early or late, or a toggle outside a falling edge, shows up as a level mismatch or a change with no edge. The bit-clock half period is measured at two divider values, which catches an off-by-one in the counter wrap. A reset in the middle of a run must restart with a left slot whose MSB is the first bit latched.

// File: rtl/i2s_mic_pkg.sv
package i2s_mic_pkg;
  localparam int unsigned SLOT_BITS   = 32;
  localparam int unsigned SAMPLE_BITS = 18;
  localparam int unsigned DIV_BITS    = 8;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/i2s_bclk_gen.sv
module i2s_bclk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             bclk_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             bclk_q;
  logic             wrap;

  assign wrap = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bclk_o = bclk_q;
  // high in the cycle whose closing edge drops bclk
  assign fall_o = wrap & bclk_q;
endmodule

// File: rtl/i2s_slot_ctrl.sv
module i2s_slot_ctrl #(
  parameter int unsigned SLOT_W = 32,
  localparam int unsigned IDX_W = $clog2(SLOT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  output logic             ws_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(SLOT_W - 1);

  logic [IDX_W-1:0] idx_q;
  logic             ws_q;

  assign last_o = fall_i & (idx_q == LastIdx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ws_q  <= 1'b0;
    end else if (fall_i) begin
      if (last_o) begin
        idx_q <= '0;
        ws_q  <= ~ws_q;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign ws_o      = ws_q;
  assign bit_idx_o = idx_q;
endmodule

// File: rtl/i2s_capture.sv
module i2s_capture #(
  parameter int unsigned SAMPLE_W = 18,
  parameter int unsigned IDX_W    = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fall_i,
  input  logic                last_i,
  input  logic [IDX_W-1:0]    bit_idx_i,
  input  logic                ws_i,
  input  logic                sd_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                chan_o,
  output logic                valid_o
);
  localparam logic [IDX_W:0] TakeLim = (IDX_W+1)'(SAMPLE_W);

  logic [SAMPLE_W-1:0] sh_q, sh_d, smp_q;
  logic                take, chan_q, vld_q;

  assign take = fall_i & ({1'b0, bit_idx_i} < TakeLim);

  generate
    if (SAMPLE_W > 1) begin : g_wide
      assign sh_d = take ? {sh_q[SAMPLE_W-2:0], sd_i} : sh_q;
    end else begin : g_one
      assign sh_d = take ? sd_i : sh_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      smp_q  <= '0;
      chan_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      vld_q <= last_i;
      if (last_i) begin
        smp_q  <= sh_d;
        chan_q <= ws_i;
      end
    end
  end

  assign sample_o = smp_q;
  assign chan_o   = chan_q;
  assign valid_o  = vld_q;
endmodule

// File: rtl/i2s_mic_rx.sv
module i2s_mic_rx
  import i2s_mic_pkg::*;
#(
  parameter int unsigned DIV_W    = DIV_BITS,
  parameter int unsigned SLOT_W   = SLOT_BITS,
  parameter int unsigned SAMPLE_W = SAMPLE_BITS,
  localparam int unsigned IDX_W   = $clog2(SLOT_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DIV_W-1:0]    div_i,
  input  logic                sd_i,
  output logic                bclk_o,
  output logic                ws_o,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                chan_o,
  output logic                sample_valid_o
);
  logic             fall;
  logic             last;
  logic             ws;
  logic [IDX_W-1:0] bit_idx;

  i2s_bclk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_i),
    .bclk_o (bclk_o),
    .fall_o (fall)
  );

  i2s_slot_ctrl #(.SLOT_W(SLOT_W)) u_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fall_i    (fall),
    .ws_o      (ws),
    .bit_idx_o (bit_idx),
    .last_o    (last)
  );

  i2s_capture #(.SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fall_i    (fall),
    .last_i    (last),
    .bit_idx_i (bit_idx),
    .ws_i      (ws),
    .sd_i      (sd_i),
    .sample_o  (sample_o),
    .chan_o    (chan_o),
    .valid_o   (sample_valid_o)
  );

  assign ws_o = ws;
endmodule

// File: rtl/i2s_mic_rx_chk.sv
module i2s_mic_rx_chk #(
  parameter int unsigned SAMPLE_W = 18
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bclk_o,
  input logic                ws_o,
  input logic [SAMPLE_W-1:0] sample_o,
  input logic                chan_o,
  input logic                sample_valid_o
);
  // R1
  rst_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!bclk_o && !ws_o && !sample_valid_o));

  // R4
  ws_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ws_o) |-> $fell(bclk_o));

  // R5
  ws_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> (ws_o != $past(ws_o)));

  // R7
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |=> !sample_valid_o);

  // R7
  sample_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_o |-> $stable(sample_o));

  // R8
  chan_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> (chan_o == $past(ws_o)));
endmodule

bind i2s_mic_rx i2s_mic_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .bclk_o         (bclk_o),
  .ws_o           (ws_o),
  .sample_o       (sample_o),
  .chan_o         (chan_o),
  .sample_valid_o (sample_valid_o)
);

// File: tb/sim_i2s_mic_rx.sv
module sim_i2s_mic_rx;
  localparam int NV = 8;
  // slot word: [31:14] sample bits 1..18, [13:0] discarded bits 19..32
  localparam logic [31:0] VEC [NV] = '{
    32'hA5A5_C000, 32'h1234_5FFF, 32'hFFFF_C000, 32'h0000_3FFF,
    32'h8000_2AAA, 32'h0000_7555, 32'hDEAD_BEEF, 32'h5555_4001
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  div = 8'd4;
  logic        sd = 1'b0;
  logic        bclk, ws, chan, vld;
  logic [17:0] smp;

  int errors = 0, checks = 0, cyc = 0;
  bit mon_on = 1'b0;

  always #4 clk = ~clk;

  i2s_mic_rx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .div_i(div), .sd_i(sd),
    .bclk_o(bclk), .ws_o(ws), .sample_o(smp), .chan_o(chan),
    .sample_valid_o(vld)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      report();
    end
  end

  // microphone model and edge monitor
  int  falls = 0, tog = 0, half = 0;
  logic prev_b = 1'b0, prev_w = 1'b0;
  always @(negedge clk) begin
    if (!rst_ni || !mon_on) begin
      falls = 0; tog = 0; half = 0; prev_b = 1'b0; prev_w = 1'b0; sd = 1'b0;
    end else begin
      half++;
      if (bclk !== prev_b) begin
        if (tog > 0) chk(half == int'(div) + 1, "R2", half, int'(div) + 1);
        tog++; half = 0;
        if (bclk) sd = VEC[(falls/32) % NV][31 - (falls % 32)];
        else begin
          falls++;
          chk(ws == 1'((falls/32) % 2), "R5", ws, (falls/32) % 2);
        end
      end else begin
        chk(ws === prev_w, "R4", ws, prev_w);
      end
      prev_b = bclk; prev_w = ws;
    end
  end

  task automatic wait_valid_and_check(input int k, input string tag);
    logic [17:0] held;
    while (!vld) @(negedge clk);
    // R3 R6: top 18 bits of slot, MSB first, sampled on falls
    chk(smp == VEC[k % NV][31:14], tag, smp, VEC[k % NV][31:14]);
    chk(chan == 1'(k % 2), "R8", chan, k % 2);
    held = smp;
    @(negedge clk);
    chk(!vld, "R7", vld, 0);
    chk(smp == held, "R7", smp, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!bclk && !ws && !vld, "R1", {bclk, ws, vld}, 0);
    rst_ni = 1'b1; mon_on = 1'b1;
    // vector table walk, div=4
    for (int k = 0; k < NV; k++) begin
      wait_valid_and_check(k, (k == 0) ? "R9 R6" : "R6");
    end
    // mid-run reset
    repeat (37) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(!bclk && !ws && !vld, "R1", {bclk, ws, vld}, 0);
    repeat (2) @(negedge clk);
    chk(!bclk && !ws && !vld, "R1", {bclk, ws, vld}, 0);
    // faster divider, restart from left slot
    div = 8'd1;
    @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < 3; k++) begin
      wait_valid_and_check(k, (k == 0) ? "R9" : "R3");
    end
    // divider 0: toggle every cycle
    rst_ni = 1'b0;
    @(negedge clk);
    div = 8'd0;
    @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < 2; k++) begin
      wait_valid_and_check(k, "R2 R6");
    end
    report();
  end
endmodule